// File: doc/BRIEF.md
# Mesh Sweep Sequencer

The sequencer walks a rectangular grid of vertices, one point at a time, and for every point hands control to an external instruction issue unit. Software writes the start bit of the control word; the sequencer then raises `busy`, visits every row from 0 up to the row limit, and within each row every column from 0 up to the column limit. At the start of each point it pulses `point_start` for one cycle with the coordinates on `point_x`/`point_y`. The issue unit uses that pulse to load its two coordinate registers and restart its program counter at 0.

The issue unit then offers one instruction per cycle over a valid/ready stream. An ordinary instruction is counted. An output instruction carries two operand words and ends the point. The sequencer stores the two words to memory as two back-to-back beats on a valid/ready write port. The first word goes to `mesh_base + 8*(128*y + x)` and the second word goes 4 bytes higher, each with its bytes reversed into big-endian order. If a point runs a whole instruction budget without an output instruction, it is abandoned with an error pulse and no memory write. After the final point, the sequencer latches the vertex count, pulses `irq` and drops `busy`.

Back-pressure rules: `ins_ready` is high only while a point is executing, so the issue unit stalls while a write is outstanding. A write beat, once `mem_valid` is high, keeps its address and data stable until `mem_ready` is seen, and the sequencer makes no progress meanwhile.

Top module: `mesh_sweep_seq`

## Requirements
- R1: A cycle with `ctl_we`=1 and `ctl_wbit0`=1 while `busy`=0 starts a sweep, and `busy` reads 1 from the next cycle until the sweep ends. A write with `ctl_wbit0`=0 starts nothing.
- R2: A start write made while `busy`=1 is ignored: no extra points are visited, and `busy` falls once the running sweep ends.
- R3: Points are visited with y outer from 0 to `v_last` inclusive and x inner from 0 to `h_last` inclusive. Each point opens with a `point_start` pulse lasting exactly one cycle, with that point's x and y on `point_x` and `point_y`.
- R4: For point (x, y), the first write beat goes to `mesh_base + 8*(128*y + x)` (modulo 2^32) and the second beat to that address + 4, in that order.
- R5: The first beat carries operand A and the second operand B, each byte-reversed: `mem_data[7:0]` = operand bits 31:24, `mem_data[15:8]` = bits 23:16, `mem_data[23:16]` = bits 15:8, `mem_data[31:24]` = bits 7:0.
- R6: While `mem_valid`=1 and `mem_ready`=0, `mem_valid`, `mem_addr` and `mem_data` stay unchanged. `ins_ready` is 0 whenever `mem_valid` is 1.
- R7: An accepted output instruction ends the point. After the second beat is accepted, `last_dma` holds that beat's address.
- R8: When 2048 ordinary instructions are accepted in one point without an output instruction, `insn_err` pulses for one cycle, the point makes no memory write, and the sweep moves on to the next point.
- R9: When the last point finishes, `vertex_count` becomes (h_last+1)*(v_last+1), `irq` pulses for exactly one cycle, and `busy` is 0 in that cycle.
- R10: After reset, `busy`, `irq`, `insn_err`, `mem_valid`, `ins_ready`, `point_start`, `vertex_count` and `last_dma` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wbit0 | input | 1 | Bit 0 of the written control word (start) |
| busy | output | 1 | Sweep in progress |
| mesh_base | input | 32 | Byte address of vertex (0,0) |
| h_last | input | 7 | Last column index |
| v_last | input | 7 | Last row index |
| point_start | output | 1 | One-cycle pulse: load coordinates, restart program at 0 |
| point_x | output | 7 | Column of the current point |
| point_y | output | 7 | Row of the current point |
| ins_valid | input | 1 | Issue unit offers an instruction |
| ins_ready | output | 1 | Sequencer accepts an instruction |
| ins_out | input | 1 | Offered instruction is an output instruction |
| ins_opa | input | 32 | Operand A of an output instruction |
| ins_opb | input | 32 | Operand B of an output instruction |
| mem_valid | output | 1 | Write beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 32 | Write byte address |
| mem_data | output | 32 | Write data, big-endian byte order |
| last_dma | output | 32 | Address of the last second-word beat written |
| vertex_count | output | 15 | Vertices in the last completed sweep |
| irq | output | 1 | One-cycle completion pulse |
| insn_err | output | 1 | One-cycle pulse when a point runs out of its instruction budget |

## Verification
On every cycle, the assertions check the pulse shape of `point_start`, `irq` and `insn_err`. They also check that a stalled write beat stays stable and that instructions are blocked while a write is outstanding, that the second beat sits 4 bytes above the first, that `last_dma` tracks the second beat, and that busy rises on a start. The bench scenarios are needed for the rest: the visiting order across the whole grid, the absolute addresses and byte order against the configured base, the vertex count, the ignored restart, and the budget abort that skips exactly one point's writes.

// File: rtl/mesh_seq_pkg.sv
package mesh_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_RUN  = 3'd2,
    ST_WR0  = 3'd3,
    ST_WR1  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/mesh_seq_coord.sv
module mesh_seq_coord #(
  parameter int COORD_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               step,
  input  logic [COORD_W-1:0] h_last,
  input  logic [COORD_W-1:0] v_last,
  output logic [COORD_W-1:0] x,
  output logic [COORD_W-1:0] y,
  output logic               last_pt
);
  logic row_end;
  assign row_end = (x == h_last);
  assign last_pt = row_end && (y == v_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else if (clear) begin
      x <= '0;
      y <= '0;
    end else if (step) begin
      if (row_end) begin
        x <= '0;
        y <= y + COORD_W'(1);
      end else begin
        x <= x + COORD_W'(1);
      end
    end
  end
endmodule

// File: rtl/mesh_seq_icount.sv
module mesh_seq_icount #(
  parameter int INSN_LIMIT = 2048,
  localparam int CNT_W = (INSN_LIMIT > 2) ? $clog2(INSN_LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = inc && (cnt == CNT_W'(INSN_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (inc)   cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/mesh_seq_wbeat.sv
module mesh_seq_wbeat #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int COORD_W    = 7,
  parameter int ROW_PITCH  = 128,
  parameter int VERT_BYTES = 8
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic               second,
  input  logic [DATA_W-1:0]  word_a,
  input  logic [DATA_W-1:0]  word_b,
  output logic [ADDR_W-1:0]  addr,
  output logic [DATA_W-1:0]  data
);
  localparam int NBYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] ROW_BYTES  = ADDR_W'(ROW_PITCH * VERT_BYTES);
  localparam logic [ADDR_W-1:0] VERT_STEP  = ADDR_W'(VERT_BYTES);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(NBYTES);

  logic [DATA_W-1:0] word;
  assign word = second ? word_b : word_a;
  assign addr = base + ADDR_W'(y) * ROW_BYTES + ADDR_W'(x) * VERT_STEP
              + (second ? WORD_BYTES : '0);

  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign data[8*b +: 8] = word[8*(NBYTES-1-b) +: 8];
  end
endmodule

// File: rtl/mesh_sweep_seq.sv
module mesh_sweep_seq
  import mesh_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int COORD_W    = 7,
  parameter int ROW_PITCH  = 128,
  parameter int VERT_BYTES = 8,
  parameter int INSN_LIMIT = 2048,
  localparam int VCNT_W    = 2 * COORD_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic               ctl_wbit0,
  output logic               busy,
  input  logic [ADDR_W-1:0]  mesh_base,
  input  logic [COORD_W-1:0] h_last,
  input  logic [COORD_W-1:0] v_last,
  output logic               point_start,
  output logic [COORD_W-1:0] point_x,
  output logic [COORD_W-1:0] point_y,
  input  logic               ins_valid,
  output logic               ins_ready,
  input  logic               ins_out,
  input  logic [DATA_W-1:0]  ins_opa,
  input  logic [DATA_W-1:0]  ins_opb,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_data,
  output logic [ADDR_W-1:0]  last_dma,
  output logic [VCNT_W-1:0]  vertex_count,
  output logic               irq,
  output logic               insn_err
);
  seq_state_t        state;
  logic [DATA_W-1:0] opa_q, opb_q;
  logic              start_ok, last_pt, expire, advance, plain_acc;

  assign busy        = (state != ST_IDLE);
  assign point_start = (state == ST_LOAD);
  assign ins_ready   = (state == ST_RUN);
  assign mem_valid   = (state == ST_WR0) || (state == ST_WR1);
  assign start_ok    = ctl_we && ctl_wbit0 && (state == ST_IDLE);
  assign plain_acc   = ins_ready && ins_valid && !ins_out;
  assign advance     = (plain_acc && expire) || ((state == ST_WR1) && mem_ready);

  mesh_seq_coord #(.COORD_W(COORD_W)) u_coord (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_ok),
    .step    (advance && !last_pt),
    .h_last  (h_last),
    .v_last  (v_last),
    .x       (point_x),
    .y       (point_y),
    .last_pt (last_pt)
  );

  mesh_seq_icount #(.INSN_LIMIT(INSN_LIMIT)) u_icount (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (point_start),
    .inc    (plain_acc),
    .expire (expire)
  );

  mesh_seq_wbeat #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COORD_W(COORD_W),
    .ROW_PITCH(ROW_PITCH), .VERT_BYTES(VERT_BYTES)
  ) u_wbeat (
    .base   (mesh_base),
    .x      (point_x),
    .y      (point_y),
    .second (state == ST_WR1),
    .word_a (opa_q),
    .word_b (opb_q),
    .addr   (mem_addr),
    .data   (mem_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      opa_q        <= '0;
      opb_q        <= '0;
      last_dma     <= '0;
      vertex_count <= '0;
      irq          <= 1'b0;
      insn_err     <= 1'b0;
    end else begin
      irq      <= 1'b0;
      insn_err <= 1'b0;
      case (state)
        ST_IDLE: if (start_ok) state <= ST_LOAD;
        ST_LOAD: state <= ST_RUN;
        ST_RUN: begin
          if (ins_valid && ins_out) begin
            opa_q <= ins_opa;
            opb_q <= ins_opb;
            state <= ST_WR0;
          end else if (plain_acc && expire) begin
            insn_err <= 1'b1;
          end
        end
        ST_WR0: if (mem_ready) state <= ST_WR1;
        ST_WR1: if (mem_ready) last_dma <= mem_addr;
        default: state <= ST_IDLE;
      endcase
      if (advance) begin
        state <= last_pt ? ST_IDLE : ST_LOAD;
        if (last_pt) begin
          irq          <= 1'b1;
          vertex_count <= (VCNT_W'(h_last) + VCNT_W'(1)) * (VCNT_W'(v_last) + VCNT_W'(1));
        end
      end
    end
  end
endmodule

// File: rtl/mesh_sweep_seq_chk.sv
module mesh_sweep_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_we,
  input logic              ctl_wbit0,
  input logic              busy,
  input logic              point_start,
  input logic              ins_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic [ADDR_W-1:0] last_dma,
  input logic              irq,
  input logic              insn_err
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_we && ctl_wbit0) |=> busy);  // R1
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    point_start |=> !point_start);  // R3
  AST_SECOND_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_valid && mem_ready) && mem_valid) |-> (mem_addr == $past(mem_addr) + ADDR_W'(4)));  // R4
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));  // R6
  AST_NO_ISSUE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !ins_ready);  // R6
  AST_LAST_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_valid && mem_ready) && !mem_valid) |-> (last_dma == $past(mem_addr)));  // R7
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    insn_err |=> !insn_err);  // R8
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    insn_err |-> !mem_valid);  // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);  // R9
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);  // R9
endmodule

bind mesh_sweep_seq mesh_sweep_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wbit0(ctl_wbit0), .busy(busy),
  .point_start(point_start), .ins_ready(ins_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
  .last_dma(last_dma), .irq(irq), .insn_err(insn_err)
);

// File: tb/mesh_sweep_seq_test.sv
module mesh_sweep_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 2048;

  typedef struct packed {
    logic [6:0]  h;
    logic [6:0]  v;
    logic [31:0] base;
    logic [3:0]  nops;
    logic        stall;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{h: 7'd0, v: 7'd0, base: 32'h0000_1000, nops: 4'd0, stall: 1'b0},
    '{h: 7'd2, v: 7'd1, base: 32'h4000_0000, nops: 4'd3, stall: 1'b1},
    '{h: 7'd1, v: 7'd2, base: 32'h0000_2008, nops: 4'd1, stall: 1'b0},
    '{h: 7'd3, v: 7'd0, base: 32'hFFFF_F000, nops: 4'd0, stall: 1'b1},
    '{h: 7'd0, v: 7'd3, base: 32'h0000_0010, nops: 4'd2, stall: 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, ctl_wbit0 = 0;
  logic [31:0] mesh_base = 0;
  logic [6:0] h_last = 0, v_last = 0;
  logic ins_valid = 0, ins_out = 0;
  logic [31:0] ins_opa = 0, ins_opb = 0;
  logic mem_ready = 1;
  logic busy, point_start, ins_ready, mem_valid, irq, insn_err;
  logic [6:0] point_x, point_y;
  logic [31:0] mem_addr, mem_data, last_dma;
  logic [14:0] vertex_count;

  int checks = 0, fails = 0;
  bit stall_mode = 0;
  int rc = 0;
  int log_n = 0, irq_n = 0, err_n = 0, pst_n = 0;
  logic [31:0] log_a [256];
  logic [31:0] log_d [256];
  logic [31:0] exp_a [64];
  logic [31:0] exp_d [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  mesh_sweep_seq uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wbit0(ctl_wbit0), .busy(busy),
    .mesh_base(mesh_base), .h_last(h_last), .v_last(v_last),
    .point_start(point_start), .point_x(point_x), .point_y(point_y),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_out(ins_out),
    .ins_opa(ins_opa), .ins_opb(ins_opb), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .last_dma(last_dma),
    .vertex_count(vertex_count), .irq(irq), .insn_err(insn_err)
  );

  always @(negedge clk) begin
    rc = rc + 1;
    mem_ready = stall_mode ? ((rc % 3) != 2) : 1'b1;
  end

  always @(posedge clk) begin
    if (mem_valid && mem_ready && log_n < 256) begin
      log_a[log_n] <= mem_addr;
      log_d[log_n] <= mem_data;
      log_n <= log_n + 1;
    end
    if (irq) irq_n <= irq_n + 1;
    if (insn_err) err_n <= err_n + 1;
    if (point_start) pst_n <= pst_n + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] be(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic wait_for_start();
    int g = 0;
    while (!point_start && g < 200) begin @(negedge clk); g++; end
  endtask

  task automatic run_sweep(input int vi, input logic [6:0] h, input logic [6:0] v,
                           input logic [31:0] base, input int nops, input bit stall,
                           input bit abort_first, input bit poke);
    int k = 0;
    int log0, irq0, err0, pst0, g;
    logic [31:0] adr, a, b;
    stall_mode = stall;
    mesh_base = base; h_last = h; v_last = v;
    log0 = log_n; irq0 = irq_n; err0 = err_n; pst0 = pst_n;
    @(negedge clk);
    ctl_we = 1; ctl_wbit0 = 1;
    @(negedge clk);
    ctl_we = 0; ctl_wbit0 = 0;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    for (int y = 0; y <= int'(v); y++) begin
      for (int x = 0; x <= int'(h); x++) begin
        wait_for_start();
        chk(point_start && point_x == 7'(x) && point_y == 7'(y), "R3 point order",
            {point_start, point_y, point_x}, {1'b1, 7'(y), 7'(x)});
        @(negedge clk);
        if (poke && x == 0 && y == 0) begin ctl_we = 1; ctl_wbit0 = 1; end
        if (abort_first && x == 0 && y == 0) begin
          for (int i = 0; i < LIMIT; i++) begin
            ins_valid = 1; ins_out = 0;
            @(negedge clk);
            ctl_we = 0; ctl_wbit0 = 0;
          end
          ins_valid = 0;
        end else begin
          for (int i = 0; i < nops; i++) begin
            ins_valid = 1; ins_out = 0;
            @(negedge clk);
            ctl_we = 0; ctl_wbit0 = 0;
          end
          a = {8'hA5, 8'(vi), 1'b0, 7'(y), 1'b0, 7'(x)};
          b = {8'h3C, 1'b0, 7'(x), 1'b0, 7'(y), 8'(vi)};
          adr = base + 32'(8 * (128 * y + x));
          exp_a[k] = adr;       exp_d[k] = be(a);
          exp_a[k+1] = adr + 4; exp_d[k+1] = be(b);
          k += 2;
          ins_valid = 1; ins_out = 1; ins_opa = a; ins_opb = b;
          @(negedge clk);
          ctl_we = 0; ctl_wbit0 = 0;
          ins_valid = 0; ins_out = 0;
        end
      end
    end
    g = 0;
    while (!irq && g < 200) begin @(negedge clk); g++; end
    chk(irq == 1'b1 && busy == 1'b0, "R9 irq with busy low", {irq, busy}, 2'b10);
    chk(vertex_count == 15'((int'(h) + 1) * (int'(v) + 1)), "R9 vertex count",
        vertex_count, (int'(h) + 1) * (int'(v) + 1));
    chk(last_dma == base + 32'(8 * (128 * int'(v) + int'(h))) + 4, "R7 last_dma",
        last_dma, base + 32'(8 * (128 * int'(v) + int'(h))) + 4);
    chk(log_n - log0 == k, "R4 write beat count", log_n - log0, k);
    for (int i = 0; i < k && i < 64; i++) begin
      chk(log_a[log0 + i] == exp_a[i], "R4 write address", log_a[log0 + i], exp_a[i]);
      chk(log_d[log0 + i] == exp_d[i], "R5 big-endian data", log_d[log0 + i], exp_d[i]);
    end
    chk(err_n - err0 == (abort_first ? 1 : 0), "R8 budget error pulses",
        err_n - err0, abort_first ? 1 : 0);
    @(negedge clk);
    chk(irq == 1'b0 && irq_n - irq0 == 1, "R9 single irq pulse", {irq, 8'(irq_n - irq0)}, 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      chk(busy == 1'b0, "R2 no restart from busy write", busy, 0);
      chk(pst_n - pst0 == (int'(h) + 1) * (int'(v) + 1), "R2 point count",
          pst_n - pst0, (int'(h) + 1) * (int'(v) + 1));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({busy, irq, insn_err, mem_valid, ins_ready, point_start} == 6'b0, "R10 reset outputs",
        {busy, irq, insn_err, mem_valid, ins_ready, point_start}, 0);
    chk(vertex_count == 0 && last_dma == 0, "R10 reset registers", {vertex_count, last_dma}, 0);

    ctl_we = 1; ctl_wbit0 = 0;
    @(negedge clk);
    ctl_we = 0;
    @(negedge clk);
    chk(busy == 1'b0 && pst_n == 0, "R1 start bit clear ignored", busy, 0);

    for (int vi = 0; vi < NVEC; vi++)
      run_sweep(vi, VECS[vi].h, VECS[vi].v, VECS[vi].base, int'(VECS[vi].nops),
                VECS[vi].stall, 1'b0, 1'b0);

    run_sweep(8, 7'd2, 7'd1, 32'h0000_8000, 1, 1'b1, 1'b0, 1'b1);   // R2 restart attempt
    run_sweep(9, 7'd1, 7'd0, 32'h0001_0000, 0, 1'b0, 1'b1, 1'b0);   // R8 budget abort

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule